// File: doc/BRIEF.md
# Ping-Pong DMA Channel with Interrupt Status

This block is one DMA channel. It holds a small state machine and the interrupt status logic that goes with it. The channel owns two beat-count descriptors. In double-buffer mode it uses them in turn, so software can refill one while the other drains. In single-buffer mode it uses only the descriptor that is currently active. A peripheral request starts each beat. A beat passes through a memory-read phase and then a memory-write phase. Either phase can stall while the memory handshake is not ready. Address generation and bus mastering are reduced to a beat counter, and each beat shows up as a one-cycle transfer strobe.

Software reaches the block through a simple write port. Address 0 is the control register, address 1 is the byte count and address 2 is the status register. Three interrupt sources feed the status register: a stall, a next-free-buffer event and completion. Each source has its own set and clear rules. A completed transfer locks the channel against new requests. The lock stays until software has both cleared the completion bit and written a fresh byte count.

Top module: `dmairq_chan`

## Requirements
- R1: After reset, `status_o` reads 0, `irq_o` is low and `xfer_o` stays low.
- R2: Control bits are: bit 0 channel enable, bit 1 double-buffer mode, bit 2 stall interrupt enable, bit 3 next-free-buffer interrupt enable, bit 4 completion interrupt enable. A byte-count write of N>0 makes a descriptor valid. While the request is held, the channel then produces exactly N `xfer_o` pulses, each beat taking one read cycle and one write cycle plus one idle cycle.
- R3: The status register holds a stall only if stall enable (control bit 2) is set when the channel goes from the read or write phase into the stall state. `status_o` bit 0 shows it. No beat completes while stalled.
- R4: A pending stall is cleared by a control write with the enable bit at 0, or by a byte-count write.
- R5: Completion is raised when the active descriptor's count runs out with no further buffer to use, or when `eot_i` is high on a beat. That beat is the last one.
- R6: Any write to the status address clears completion, whatever the data. Completion shows in `status_o` bit 2 only while control bit 4 is set, but it is recorded either way.
- R7: While completion is pending, or after it until the next byte-count write, requests are ignored and no strobe appears.
- R8: In double-buffer mode, when the active descriptor empties and the other one is valid, the channel switches to it and raises next-free-buffer (`status_o` bit 1) if control bit 3 is set.
- R9: A pending next-free-buffer is cleared by a byte-count write or by a control write with the enable bit at 0. A status write does not clear it.
- R10: Next-free-buffer is never raised in single-buffer mode. A byte-count write there always loads the active descriptor.
- R11: `status_o` bits above bit 2 read 0. `irq_o` is the OR of the shown status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 byte count, 2 status |
| wr_data | input | DATA_W | Write data |
| dreq_i | input | 1 | Peripheral request |
| eot_i | input | 1 | External end of transfer, sampled on a beat |
| mem_rdy_i | input | 1 | Memory handshake ready; low stalls the channel |
| status_o | output | STAT_W | Interrupt status read-back |
| irq_o | output | 1 | Combined interrupt |
| xfer_o | output | 1 | One pulse per completed beat |

## Verification
- A register write takes effect on the clock edge that samples it, so the bench checks `status_o` and `irq_o` at the falling edge right after the write.
- A beat reaches its write phase two edges after the request is first seen while idle. The `xfer_o` pulse falls in that write cycle.
- Completion, next-free-buffer and the start of a stall each become visible one edge after the event that causes them.
- The bench holds the request for a window that covers three cycles per expected beat. It counts strobes at falling edges, then waits for the channel to settle before it reads status. The result therefore does not depend on the exact edge, yet a missing or extra beat still shows up.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_MEM_RD = 3'd1,
    ST_MEM_WR = 3'd2,
    ST_STALL  = 3'd3,
    ST_NEXT   = 3'd4
  } chan_state_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_BCNT = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  localparam int CTL_W        = 5;
  localparam int CTL_EN       = 0;
  localparam int CTL_DBL      = 1;
  localparam int CTL_STALL_IE = 2;
  localparam int CTL_NFB_IE   = 3;
  localparam int CTL_DONE_IE  = 4;

  localparam int SRC_W        = 3;
  localparam int SB_STALL     = 0;
  localparam int SB_NFB       = 1;
  localparam int SB_DONE      = 2;

  localparam int NDESC        = 2;

endpackage

// File: rtl/dmairq_desc.sv
module dmairq_desc
  import dmairq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             load_sel_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             kill_i,
  input  logic             act_sel_i,
  output logic [NDESC-1:0] valid_o,
  output logic             act_last_o
);

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] c);
    return c - CNT_W'(1);
  endfunction

  function automatic logic final_beat(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] cnt_w [NDESC];

  for (genvar g = 0; g < NDESC; g++) begin : g_desc
    logic [CNT_W-1:0] cnt_q;
    logic             vld_q;
    logic             sel_load;
    logic             sel_act;

    assign sel_load = load_i && (load_sel_i == 1'(g));
    assign sel_act  = act_sel_i == 1'(g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q <= '0;
        vld_q <= 1'b0;
      end else if (sel_load) begin
        cnt_q <= load_val_i;
        vld_q <= load_val_i != '0;
      end else if (sel_act && (dec_i || kill_i)) begin
        if (dec_i) cnt_q <= step_down(cnt_q);
        if (kill_i || (dec_i && final_beat(cnt_q))) vld_q <= 1'b0;
      end
    end

    assign cnt_w[g]   = cnt_q;
    assign valid_o[g] = vld_q;
  end

  assign act_last_o = final_beat(cnt_w[act_sel_i]);

  // R2: the beat that empties a descriptor drops its valid flag
  p_empty_drops_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && act_last_o && !(load_i && load_sel_i == act_sel_i))
      |=> !valid_o[$past(act_sel_i)]);

endmodule

// File: rtl/dmairq_fsm.sv
module dmairq_fsm
  import dmairq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dbl_i,
  input  logic blocked_i,
  input  logic dreq_i,
  input  logic mem_rdy_i,
  input  logic eot_i,
  input  logic act_valid_i,
  input  logic act_last_i,
  input  logic other_valid_i,
  output logic beat_o,
  output logic switch_o,
  output logic stall_evt_o,
  output logic finish_o,
  output logic kill_o
);

  chan_state_e st_q, st_d, ret_q, ret_d;

  always_comb begin
    st_d     = st_q;
    ret_d    = ret_q;
    beat_o   = 1'b0;
    switch_o = 1'b0;
    finish_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en_i && !blocked_i && dreq_i && act_valid_i) st_d = ST_MEM_RD;
      end
      ST_MEM_RD: begin
        if (!en_i) st_d = ST_IDLE;
        else if (!mem_rdy_i) begin
          st_d  = ST_STALL;
          ret_d = ST_MEM_RD;
        end else st_d = ST_MEM_WR;
      end
      ST_MEM_WR: begin
        if (!en_i) st_d = ST_IDLE;
        else if (!mem_rdy_i) begin
          st_d  = ST_STALL;
          ret_d = ST_MEM_WR;
        end else begin
          beat_o = 1'b1;
          st_d   = ST_IDLE;
          if (eot_i || act_last_i) begin
            if (!eot_i && dbl_i && other_valid_i) st_d = ST_NEXT;
            else finish_o = 1'b1;
          end
        end
      end
      ST_STALL: begin
        if (!en_i) st_d = ST_IDLE;
        else if (mem_rdy_i) st_d = ret_q;
      end
      ST_NEXT: begin
        switch_o = 1'b1;
        st_d     = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign stall_evt_o = (st_q == ST_MEM_RD || st_q == ST_MEM_WR) && st_d == ST_STALL;
  assign kill_o      = beat_o && eot_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      ret_q <= ST_MEM_RD;
    end else begin
      st_q  <= st_d;
      ret_q <= ret_d;
    end
  end

  // R3: the stall state is only ever entered from a memory phase
  p_stall_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STALL && $past(st_q) != ST_STALL)
      |-> ($past(st_q) == ST_MEM_RD || $past(st_q) == ST_MEM_WR));

  // R7: a locked channel never leaves idle for a read phase
  p_locked_no_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && blocked_i) |=> st_q != ST_MEM_RD);

  // R10: buffer switching happens only in double-buffer mode
  p_switch_double_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_MEM_WR && st_d == ST_NEXT) |-> dbl_i);

endmodule

// File: rtl/dmairq_irq.sv
module dmairq_irq
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_ie_i,
  input  logic             nfb_ie_i,
  input  logic             done_ie_i,
  input  logic             evt_stall_i,
  input  logic             evt_nfb_i,
  input  logic             evt_done_i,
  input  logic             clr_chan_i,
  input  logic             clr_bcnt_i,
  input  logic             clr_stat_i,
  output logic [SRC_W-1:0] stat_o,
  output logic             irq_o,
  output logic             blocked_o
);

  logic stall_q, nfb_q, done_q, rearm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      nfb_q   <= 1'b0;
      done_q  <= 1'b0;
      rearm_q <= 1'b0;
    end else begin
      if (evt_stall_i && stall_ie_i)     stall_q <= 1'b1;
      else if (clr_chan_i || clr_bcnt_i) stall_q <= 1'b0;

      if (evt_nfb_i && nfb_ie_i)         nfb_q <= 1'b1;
      else if (clr_chan_i || clr_bcnt_i) nfb_q <= 1'b0;

      if (evt_done_i)      done_q <= 1'b1;
      else if (clr_stat_i) done_q <= 1'b0;

      if (evt_done_i)      rearm_q <= 1'b1;
      else if (clr_bcnt_i) rearm_q <= 1'b0;
    end
  end

  always_comb begin
    stat_o           = '0;
    stat_o[SB_STALL] = stall_q;
    stat_o[SB_NFB]   = nfb_q;
    stat_o[SB_DONE]  = done_q && done_ie_i;
  end

  assign irq_o     = |stat_o;
  assign blocked_o = done_q || rearm_q;

  // R3: no stall is recorded while its enable is off
  p_stall_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_ie_i && !stall_q) |=> !stall_q);

  // R4: disable or byte-count write removes a pending stall
  p_stall_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_chan_i || clr_bcnt_i) && !evt_stall_i) |=> !stall_q);

  // R5: a completion event is always recorded
  p_done_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done_i |=> blocked_o);

  // R6: status write removes completion
  p_done_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat_i && !evt_done_i) |=> !stat_o[SB_DONE]);

  // R9: a status write leaves next-free-buffer untouched
  p_nfb_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stat_i && !clr_chan_i && !clr_bcnt_i && nfb_q) |=> nfb_q);

endmodule

// File: rtl/dmairq_chan.sv
module dmairq_chan
  import dmairq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dreq_i,
  input  logic              eot_i,
  input  logic              mem_rdy_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              xfer_o
);

  localparam int PAD_W = STAT_W - SRC_W;

  logic [CTL_W-1:0] ctrl_q;
  logic             act_q;
  logic [NDESC-1:0] dvalid;
  logic             act_last;
  logic             blocked;
  logic [SRC_W-1:0] stat;

  // named events between the pieces
  logic wr_ctrl, wr_bcnt, wr_stat, clr_chan;
  logic ev_beat, ev_switch, ev_stall, ev_done, ev_kill;
  logic load_sel;

  assign wr_ctrl  = wr_en && wr_addr == ADDR_CTRL;
  assign wr_bcnt  = wr_en && wr_addr == ADDR_BCNT;
  assign wr_stat  = wr_en && wr_addr == ADDR_STAT;
  assign clr_chan = wr_ctrl && !wr_data[CTL_EN];

  assign load_sel = (ctrl_q[CTL_DBL] && dvalid[act_q]) ? ~act_q : act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      act_q  <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q <= wr_data[CTL_W-1:0];
      if (ev_switch) act_q  <= ~act_q;
    end
  end

  dmairq_desc #(.CNT_W(DATA_W)) u_desc (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_bcnt),
    .load_sel_i (load_sel),
    .load_val_i (wr_data),
    .dec_i      (ev_beat),
    .kill_i     (ev_kill),
    .act_sel_i  (act_q),
    .valid_o    (dvalid),
    .act_last_o (act_last)
  );

  dmairq_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_i          (ctrl_q[CTL_EN]),
    .dbl_i         (ctrl_q[CTL_DBL]),
    .blocked_i     (blocked),
    .dreq_i        (dreq_i),
    .mem_rdy_i     (mem_rdy_i),
    .eot_i         (eot_i),
    .act_valid_i   (dvalid[act_q]),
    .act_last_i    (act_last),
    .other_valid_i (dvalid[~act_q]),
    .beat_o        (ev_beat),
    .switch_o      (ev_switch),
    .stall_evt_o   (ev_stall),
    .finish_o      (ev_done),
    .kill_o        (ev_kill)
  );

  dmairq_irq u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_ie_i  (ctrl_q[CTL_STALL_IE]),
    .nfb_ie_i    (ctrl_q[CTL_NFB_IE]),
    .done_ie_i   (ctrl_q[CTL_DONE_IE]),
    .evt_stall_i (ev_stall),
    .evt_nfb_i   (ev_switch),
    .evt_done_i  (ev_done),
    .clr_chan_i  (clr_chan),
    .clr_bcnt_i  (wr_bcnt),
    .clr_stat_i  (wr_stat),
    .stat_o      (stat),
    .irq_o       (irq_o),
    .blocked_o   (blocked)
  );

  assign status_o = {{PAD_W{1'b0}}, stat};
  assign xfer_o   = ev_beat;

  // R8: a switch to the other descriptor requires it to be valid
  p_switch_to_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_switch |-> dvalid[~act_q]);

  // R11: reserved status bits stay at zero
  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-1:SRC_W] == '0);

endmodule

// File: tb/dmairq_chan_bench.sv
`timescale 1ns/1ps
module dmairq_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        dreq_i = 1'b0;
  logic        eot_i = 1'b0;
  logic        mem_rdy_i = 1'b1;
  logic [7:0]  status_o;
  logic        irq_o;
  logic        xfer_o;

  int checks = 0;
  int errors = 0;
  int beats  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmairq_chan u_dmairq_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dreq_i(dreq_i), .eot_i(eot_i),
    .mem_rdy_i(mem_rdy_i), .status_o(status_o), .irq_o(irq_o),
    .xfer_o(xfer_o)
  );

  always @(negedge clk) if (rst_n && xfer_o) beats++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold the request for a window, then let any beat in flight finish
  task automatic run(input int window);
    @(negedge clk);
    beats  = 0;
    dreq_i = 1'b1;
    idle(window);
    dreq_i = 1'b0;
    idle(4);
  endtask

  task automatic t_reset();
    idle(2);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 xfer", xfer_o, 0);
    rst_n = 1'b1;
    idle(2);
  endtask

  task automatic t_single_done();
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'd3);
    run(30);
    chk("R2 beats for count 3", beats, 3);
    chk("R5 done shown", status_o, 4);
    chk("R11 irq from done", irq_o, 1);
  endtask

  task automatic t_block();
    run(20);
    chk("R7 locked while done", beats, 0);
    wr(2'd2, 16'h0000);
    chk("R6 cleared by zero write", status_o, 0);
    chk("R11 irq low", irq_o, 0);
    run(20);
    chk("R7 still locked without byte count", beats, 0);
    wr(2'd1, 16'd2);
    run(30);
    chk("R7 runs after rearm", beats, 2);
    wr(2'd2, 16'hFFFF);
    chk("R6 cleared by ones write", status_o, 0);
  endtask

  task automatic t_done_masked();
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd1);
    run(20);
    chk("R2 one beat", beats, 1);
    chk("R6 masked done not shown", status_o, 0);
    chk("R11 irq masked", irq_o, 0);
    wr(2'd1, 16'd3);
    run(20);
    chk("R7 masked done still locks", beats, 0);
    wr(2'd2, 16'h0000);
    run(30);
    chk("R7 runs after clear", beats, 3);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_stall();
    wr(2'd0, 16'h0015);
    wr(2'd1, 16'd2);
    mem_rdy_i = 1'b0;
    run(6);
    chk("R3 no beat while stalled", beats, 0);
    chk("R3 stall shown", status_o, 1);
    chk("R11 irq from stall", irq_o, 1);
    mem_rdy_i = 1'b1;
    run(30);
    chk("R3 beats resume", beats, 2);
    chk("R5 stall and done", status_o, 5);
    wr(2'd2, 16'h0000);
    chk("R6 stall kept by status write", status_o, 1);
    wr(2'd1, 16'd2);
    chk("R4 byte count clears stall", status_o, 0);
    mem_rdy_i = 1'b0;
    run(6);
    chk("R3 stall again", status_o, 1);
    wr(2'd0, 16'h0014);
    chk("R4 disable clears stall", status_o, 0);
    mem_rdy_i = 1'b1;
    wr(2'd0, 16'h0011);
    mem_rdy_i = 1'b0;
    run(6);
    chk("R3 stall masked", status_o, 0);
    mem_rdy_i = 1'b1;
    run(30);
    chk("R2 masked stall beats", beats, 2);
    chk("R5 done after stall", status_o, 4);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_double();
    wr(2'd0, 16'h001B);
    wr(2'd1, 16'd2);
    wr(2'd1, 16'd2);
    run(40);
    chk("R8 both buffers drained", beats, 4);
    chk("R8 next free and done", status_o, 6);
    wr(2'd2, 16'h0000);
    chk("R9 status write keeps next free", status_o, 2);
    wr(2'd1, 16'd1);
    chk("R9 byte count clears next free", status_o, 0);
    wr(2'd1, 16'd1);
    run(30);
    chk("R8 second pair drained", beats, 2);
    chk("R8 next free again", status_o, 6);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h001A);
    chk("R9 disable clears next free", status_o, 0);
  endtask

  task automatic t_single_no_nfb();
    wr(2'd0, 16'h0019);
    wr(2'd1, 16'd2);
    wr(2'd1, 16'd2);
    run(30);
    chk("R10 single mode overwrites", beats, 2);
    chk("R10 no next free", status_o, 4);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_eot();
    wr(2'd0, 16'h0011);
    wr(2'd1, 16'd5);
    eot_i = 1'b1;
    run(30);
    eot_i = 1'b0;
    chk("R5 end of transfer stops early", beats, 1);
    chk("R5 done on end of transfer", status_o, 4);
    run(20);
    chk("R7 locked after end of transfer", beats, 0);
  endtask

  initial begin
    t_reset();
    t_single_done();
    t_block();
    t_done_masked();
    t_stall();
    t_double();
    t_single_no_nfb();
    t_eot();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule